// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block catches a program that has stopped servicing it. A down-counter of `CNT_W` bits (15 by default) steps once per enable pulse from a prescaler that runs on the bus clock. When the counter steps below zero, the block raises either an interrupt request or a system reset request. A sticky mode bit picks which one.

The prescaler divides by 16 or by 128 while the main oscillator drives the bus. A control input picks between those two ratios. While the sub-clock oscillator drives the bus, the prescaler divides by 2 and the control input has no effect. One timeout therefore lasts the ratio times 2^`CNT_W` bus clocks. At 10 MHz with a ratio of 16 and a 15-bit counter, that is about 52.4 ms.

After a system reset the unit is idle. Software starts it with a strobe on the start register. Every later strobe reloads the counter and services the watchdog. The prescaler phase is cleared only by system reset.

Top module: `wdog_prescaled`

## Requirements
- R1: After rst_ni is released, irq_o and rst_req_o are 0. The unit stays halted and emits no pulse, whatever the other inputs do, until the first start_wr_i strobe.
- R2: A start_wr_i strobe loads the counter with all ones. From the first strobe after reset, the first underflow pulse comes ratio x 2^CNT_W clock edges after the strobe edge. The unit then keeps running.
- R3: With sub_clk_i = 0, the ratio is 16 when div_hi_i = 0 and 128 when div_hi_i = 1.
- R4: With sub_clk_i = 1, the ratio is 2 for both values of div_hi_i.
- R5: With the mode bit at 0, an underflow gives a one-cycle pulse on irq_o. The counter reloads by itself, and the next pulse follows exactly one period (ratio x 2^CNT_W) later.
- R6: With the mode bit at 1, an underflow gives a one-cycle pulse on rst_req_o, and irq_o stays 0.
- R7: A write with mode_wr_i = 1 and mode_wdata_i = 1 sets the mode bit. A later write of 0 has no effect. Only rst_ni clears the mode bit.
- R8: A start strobe reloads the counter but keeps the prescaler phase. A strobe at phase p (edges since the last prescaler wrap) is followed by the next pulse ratio x 2^CNT_W - p edges later.
- R9: A change of div_hi_i or sub_clk_i takes effect only at the prescaler's next terminal count. The count already in progress finishes with the old ratio.
- R10: If a start strobe falls in the cycle of an underflow, the strobe wins. No pulse is raised, and the next pulse comes one full period later.
- R11: irq_o and rst_req_o are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| start_wr_i | input | 1 | Start register write strobe |
| div_hi_i | input | 1 | Ratio select on main oscillator: 0 = /16, 1 = /128 |
| sub_clk_i | input | 1 | 1 = bus clock from sub-clock oscillator (/2) |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 1 | Mode bit write data: 1 = reset on underflow |
| irq_o | output | 1 | Watchdog interrupt request pulse |
| rst_req_o | output | 1 | Watchdog reset request pulse |

## Verification
A table walks all four combinations of clock source and ratio bit. It measures the first timeout from a start strobe, which separates the three ratios and shows that the ratio bit is ignored under the sub-clock. Directed runs then time a second period to show the self-reload, and restart at a known prescaler phase to show that the phase survives a strobe. They also switch the ratio mid-count to show that the switch waits for the terminal count, and collide a strobe with an underflow. Mode tests compare a mode write of 1 followed by 0 against a fresh reset, which separates a sticky bit from a plain one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    DIV_MAIN_LO = 2'd0,
    DIV_MAIN_HI = 2'd1,
    DIV_SUB     = 2'd2
  } wdog_div_e;

  function automatic wdog_div_e pick_div(input logic sub_clk, input logic div_hi);
    if (sub_clk)     return DIV_SUB;
    else if (div_hi) return DIV_MAIN_HI;
    else             return DIV_MAIN_LO;
  endfunction

endpackage

// File: rtl/wdog_ratio_sel.sv
module wdog_ratio_sel
  import wdog_pkg::*;
#(
  parameter int DIV_LO  = 16,
  parameter int DIV_HI  = 128,
  parameter int DIV_SUB = 2,
  parameter int PRE_W   = 7
) (
  input  logic             sub_clk_i,
  input  logic             div_hi_i,
  output logic [PRE_W-1:0] ratio_m1_o
);

  wdog_div_e div_sel;

  always_comb begin
    div_sel = pick_div(sub_clk_i, div_hi_i);
    unique case (div_sel)
      DIV_SUB:     ratio_m1_o = PRE_W'(DIV_SUB - 1);
      DIV_MAIN_HI: ratio_m1_o = PRE_W'(DIV_HI - 1);
      default:     ratio_m1_o = PRE_W'(DIV_LO - 1);
    endcase
  end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [PRE_W-1:0] ratio_m1_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim_q;
  logic             term;

  assign term   = (pre_q == lim_q);
  assign tick_o = run_i && term;

  // limit is sampled only at wrap (or at first start), so ratio changes wait for terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      lim_q <= '0;
    end else begin
      if (load_i) lim_q <= ratio_m1_i;
      if (run_i) begin
        if (term) begin
          pre_q <= '0;
          lim_q <= ratio_m1_i;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  a_r1_halted_prescaler: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pre_q));

  a_r9_limit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !term && !load_i) |=> $stable(lim_q));

endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int CNT_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic start_i,
  output logic uflow_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // a start strobe masks the underflow of the same cycle
  assign uflow_o = run_i && tick_i && (cnt_q == '0) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= CntMax;
    else if (start_i || uflow_o)  cnt_q <= CntMax;
    else if (run_i && tick_i)     cnt_q <= cnt_q - 1'b1;
  end

  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == CntMax));

  a_r5_reload_after_uflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o |=> (cnt_q == CntMax));

endmodule

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  output logic mode_o
);

  // set-only: software can raise it, only system reset drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mode_o <= 1'b0;
    else if (wr_i && wdata_i)  mode_o <= 1'b1;
  end

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |=> mode_o);

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int CNT_W   = 15,
  parameter int DIV_LO  = 16,
  parameter int DIV_HI  = 128,
  parameter int DIV_SUB = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic div_hi_i,
  input  logic sub_clk_i,
  input  logic mode_wr_i,
  input  logic mode_wdata_i,
  output logic irq_o,
  output logic rst_req_o
);

  localparam int DivMaxA = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int DivMax  = (DivMaxA > DIV_SUB) ? DivMaxA : DIV_SUB;
  localparam int PRE_W   = (DivMax > 2) ? $clog2(DivMax) : 1;

  logic             run_q;
  logic [PRE_W-1:0] ratio_m1;
  logic             tick;
  logic             uflow;
  logic             mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= 1'b0;
    else if (start_wr_i) run_q <= 1'b1;
  end

  wdog_ratio_sel #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI),
    .DIV_SUB(DIV_SUB),
    .PRE_W  (PRE_W)
  ) u_ratio (
    .sub_clk_i (sub_clk_i),
    .div_hi_i  (div_hi_i),
    .ratio_m1_o(ratio_m1)
  );

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .load_i    (start_wr_i && !run_q),
    .ratio_m1_i(ratio_m1),
    .tick_o    (tick)
  );

  wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .tick_i (tick),
    .start_i(start_wr_i),
    .uflow_o(uflow)
  );

  wdog_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (mode_wr_i),
    .wdata_i(mode_wdata_i),
    .mode_o (mode)
  );

  assign irq_o     = uflow && !mode;
  assign rst_req_o = uflow && mode;

  a_r1_no_pulse_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !(irq_o || rst_req_o));

  a_r10_start_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i |-> !(irq_o || rst_req_o));

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));

  a_r11_single_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r11_single_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

endmodule

// File: tb/wdog_prescaled_tb.sv
module wdog_prescaled_tb;

  localparam int CW  = 6;
  localparam int CNT = 1 << CW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_wr = 1'b0, div_hi = 1'b0, sub_clk = 1'b0, mode_wr = 1'b0, mode_wdata = 1'b0;
  logic irq, rst_req;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_prescaled #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_wr_i(start_wr), .div_hi_i(div_hi),
    .sub_clk_i(sub_clk), .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  // {sub_clk, div_hi, expected first timeout}
  localparam int VEC [4][3] = '{
    '{0, 0, 16 * CNT},
    '{0, 1, 128 * CNT},
    '{1, 0, 2 * CNT},
    '{1, 1, 2 * CNT}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    start_wr = 0; mode_wr = 0; mode_wdata = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // strobe start; returns cyc seen at the negedge after the strobe edge
  task automatic do_start(output int c0);
    @(negedge clk);
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    c0 = cyc;
  endtask

  task automatic mode_write(input logic v);
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0; mode_wdata = 1'b0;
  endtask

  // wait for next pulse; returns its cyc stamp and kind (1 irq, 2 rst_req, 0 none)
  task automatic wait_pulse(input int limit, output int pc, output int kind);
    pc = -1; kind = 0;
    for (int i = 0; i < limit; i++) begin
      if (i != 0) @(negedge clk);
      if (irq || rst_req) begin
        pc = cyc;
        kind = irq ? 1 : 2;
        return;
      end
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int c0, c1, p, p2, k, seen;

    // R1: reset state, no pulse before first start
    do_reset();
    @(negedge clk);
    chk("R1 irq at reset", int'(irq), 0);
    chk("R1 rst_req at reset", int'(rst_req), 0);
    sub_clk = 1;
    seen = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (irq || rst_req) seen++;
    end
    chk("R1 pulses while halted", seen, 0);

    // R2 R3 R4: ratio table
    for (int v = 0; v < 4; v++) begin
      do_reset();
      sub_clk = VEC[v][0][0];
      div_hi  = VEC[v][1][0];
      do_start(c0);
      wait_pulse(20000, p, k);
      chk(VEC[v][0] != 0 ? "R4 sub-clock period" : "R3 main period", p - c0 + 1, VEC[v][2]);
      chk("R2 first pulse kind irq", k, 1);
    end

    // R5 R11: self reload and pulse width
    do_reset();
    sub_clk = 0; div_hi = 0;
    do_start(c0);
    wait_pulse(20000, p, k);
    @(negedge clk);
    chk("R11 irq width one cycle", int'(irq), 0);
    wait_pulse(20000, p2, k);
    chk("R5 second period", p2 - p, 16 * CNT);

    // R8: restart at prescaler phase 5 keeps phase
    do_reset();
    sub_clk = 0; div_hi = 0;
    do_start(c0);
    wait_until(c0 + 16 * 2 + 5 - 1);
    start_wr = 1;
    @(negedge clk);
    start_wr = 0;
    c1 = cyc;
    wait_pulse(20000, p, k);
    chk("R8 restart keeps phase", p - c1 + 1, 16 * CNT - 5);

    // R9: ratio change mid-count waits for terminal count
    do_reset();
    sub_clk = 0; div_hi = 0;
    do_start(c0);
    wait_until(c0 + 5);
    sub_clk = 1;
    wait_pulse(20000, p, k);
    chk("R9 ratio change at wrap", p - c0 + 1, 16 + 2 * (CNT - 1));

    // R10: start in underflow cycle wins
    do_reset();
    sub_clk = 1;
    do_start(c0);
    wait_until(c0 + 2 * CNT - 1);
    start_wr = 1;
    #1;
    chk("R10 irq masked by start", int'(irq), 0);
    @(negedge clk);
    start_wr = 0;
    c1 = cyc;
    wait_pulse(20000, p, k);
    chk("R10 full period after collision", p - c1 + 1, 2 * CNT);

    // R6 R7: sticky reset mode
    do_reset();
    sub_clk = 1;
    mode_write(1'b1);
    mode_write(1'b0);
    do_start(c0);
    wait_pulse(20000, p, k);
    chk("R6 reset request kind", k, 2);
    chk("R7 mode stays set, period", p - c0 + 1, 2 * CNT);
    chk("R11 irq low during rst_req", int'(irq), 0);
    @(negedge clk);
    chk("R11 rst_req width one cycle", int'(rst_req), 0);

    // R7: only reset clears mode
    do_reset();
    sub_clk = 1;
    do_start(c0);
    wait_pulse(20000, p, k);
    chk("R7 reset clears mode", k, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule